// File: doc/BRIEF.md
# Way-Predicting Branch Target Buffer

This block is a set-associative branch target buffer that also remembers, for each fetch address it holds, which way of a 4-way instruction cache last supplied that fetch. A single combinational probe per fetch returns a hit flag, the branch target and taken flag for branch entries, and a 2-bit cache-way prediction with a valid flag. From the prediction the block drives a 4-bit way-enable vector for the instruction cache. When a prediction is valid, only the predicted way is enabled. Otherwise all four ways are enabled.

Fetches that contain no branch are allocated entries too, so more fetches receive a way prediction. The buffer's ways are split statically into two groups. One group holds branch entries, which carry a target, a taken flag and a cache way. The other group holds plain entries, which carry only a cache way. A probe searches both groups at once, and the branch group wins when both hit. After each fetch an update port reports the way that actually hit, the branch outcome and the target. An update that hits its own group rewrites the entry. An update that misses allocates into its own group.

If the cache reports a miss after a fetch that used a prediction, the block raises a one-cycle mispredict pulse. The pipeline then re-fetches with all ways enabled, and the next update corrects the stored way.

Top module: `way_pred_btb`

## Requirements
- R1: Reset clears every valid bit. After reset, every probe misses: `lk_hit`=0, `lk_way_valid`=0, and `ic_way_en`=4'b1111.
- R2: The set index is `lk_addr[7:2]` and the tag is `lk_addr[31:8]`. A probe that hits a branch entry returns, in the same cycle, `lk_hit`=1, `lk_is_branch`=1, the stored target on `lk_target`, the stored taken flag on `lk_taken`, and the stored cache way on `lk_way` with `lk_way_valid`=1.
- R3: `ic_way_en` is one-hot with bit `lk_way` set when `lk_way_valid`=1. Otherwise it is 4'b1111.
- R4: An update with `up_is_branch`=0 creates a plain entry. A probe that hits it returns `lk_hit`=1, `lk_way_valid`=1, the stored way, `lk_is_branch`=0, `lk_taken`=0 and `lk_target`=0.
- R5: Branch updates allocate only into the two branch ways, and plain updates allocate only into the two plain ways of a set. Branch allocations never evict a plain entry.
- R6: When one address hits in both groups, the probe returns the branch entry's way, target and taken flag.
- R7: An update that hits an entry in its own group overwrites that entry's way, and for branches also its target and taken flag. The other entries in the set are not disturbed.
- R8: On a miss, the update writes the first invalid way of its group, or, if both ways are valid, the way named by the group's per-set replacement bit. After each write the bit points at the other way.
- R9: If an update and a probe address the same set in the same cycle, the probe returns the contents as they are after the update.
- R10: A probe at cycle t that has `lk_valid`=1 and `lk_way_valid`=1, followed at cycle t+1 by `ic_resp_valid`=1 with `ic_resp_hit`=0, drives `way_mispredict` high for exactly cycle t+2. No pulse occurs when the cache hits or when no prediction was used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Probe request this cycle |
| lk_addr | input | 32 | Fetch address to probe |
| lk_hit | output | 1 | Probe hit in either group |
| lk_is_branch | output | 1 | Hit came from the branch group |
| lk_taken | output | 1 | Stored taken flag of the branch hit |
| lk_target | output | 32 | Stored target of the branch hit, else 0 |
| lk_way_valid | output | 1 | A cache-way prediction is available |
| lk_way | output | 2 | Predicted instruction-cache way |
| ic_way_en | output | 4 | Instruction-cache way enables |
| up_valid | input | 1 | Update request this cycle |
| up_addr | input | 32 | Fetch address being trained |
| up_way | input | 2 | Cache way that actually hit |
| up_is_branch | input | 1 | Fetch contained a branch |
| up_taken | input | 1 | Resolved branch direction |
| up_target | input | 32 | Resolved branch target |
| ic_resp_valid | input | 1 | Cache result for the previous probe is present |
| ic_resp_hit | input | 1 | Cache hit in the enabled way(s) |
| way_mispredict | output | 1 | One-cycle pulse: predicted way missed |

## Verification
The bench fills one set with three branch addresses after placing a plain entry there. A design with the wrong replacement bit evicts the wrong branch entry, and a design without partitioning evicts the plain entry. It loads one address into both groups, which exposes a design that lets the plain way win. It issues an update and a probe in the same cycle, which exposes a design that returns stale or missing data instead of forwarding. It times the mispredict pulse to a single cycle and checks that no pulse follows a cache hit or an unpredicted fetch. A wrong pipeline depth or a missing qualifier shows up as a pulse in the wrong cycle. A final reset after training checks that all entries are forgotten.

// File: rtl/wpb_pkg.sv
package wpb_pkg;

    localparam int ADDR_W     = 32;
    localparam int IC_WAYS    = 4;
    localparam int WAY_W      = $clog2(IC_WAYS);
    localparam int OFS_W      = 2;
    localparam int IDX_W      = 6;
    localparam int SETS       = 1 << IDX_W;
    localparam int TAG_W      = ADDR_W - IDX_W - OFS_W;
    localparam int GROUP_WAYS = 2;
    localparam int N_GROUPS   = 2;

    typedef logic [ADDR_W-1:0]  addr_t;
    typedef logic [IDX_W-1:0]   set_t;
    typedef logic [TAG_W-1:0]   tag_t;
    typedef logic [WAY_W-1:0]   icway_t;
    typedef logic [IC_WAYS-1:0] wayen_t;

    // group order is also probe priority: lower index wins
    typedef enum logic {
        GRP_BRANCH = 1'b0,
        GRP_PLAIN  = 1'b1
    } group_e;

    typedef struct packed {
        tag_t   tag;
        icway_t icway;
        logic   taken;
        addr_t  target;
    } entry_t;

    typedef struct packed {
        logic   hit;
        icway_t icway;
        logic   taken;
        addr_t  target;
    } probe_t;

    function automatic set_t set_of(input addr_t a);
        return a[OFS_W +: IDX_W];
    endfunction

    function automatic tag_t tag_of(input addr_t a);
        return a[ADDR_W-1 -: TAG_W];
    endfunction

    function automatic wayen_t way_enable(input logic pred_ok, input icway_t w);
        wayen_t en;
        en = '1;
        if (pred_ok) en = wayen_t'(1) << w;
        return en;
    endfunction

endpackage

// File: rtl/wpb_group.sv
module wpb_group
    import wpb_pkg::*;
#(
    parameter int NSETS = wpb_pkg::SETS,
    parameter int NWAYS = wpb_pkg::GROUP_WAYS
) (
    input  logic   clk,
    input  logic   rst,
    input  set_t   lk_set,
    input  tag_t   lk_tag,
    output probe_t probe,
    input  logic   wr_en,
    input  set_t   wr_set,
    input  entry_t wr_ent
);
    localparam int VW = (NWAYS > 1) ? $clog2(NWAYS) : 1;
    typedef logic [VW-1:0] vsel_t;

    logic [NWAYS-1:0] vld_q [NSETS];
    entry_t           ent_q [NSETS][NWAYS];
    vsel_t            ptr_q [NSETS];

    logic  u_hit;
    vsel_t u_hit_way;
    vsel_t victim;
    logic  free_found;
    vsel_t wr_way;
    vsel_t ptr_nxt;

    // update side: find matching entry or choose victim
    always_comb begin
        u_hit      = 1'b0;
        u_hit_way  = '0;
        free_found = 1'b0;
        victim     = ptr_q[wr_set];
        for (int w = 0; w < NWAYS; w++) begin
            if (!u_hit && vld_q[wr_set][w] && ent_q[wr_set][w].tag == wr_ent.tag) begin
                u_hit     = 1'b1;
                u_hit_way = vsel_t'(w);
            end
            if (!free_found && !vld_q[wr_set][w]) begin
                free_found = 1'b1;
                victim     = vsel_t'(w);
            end
        end
        wr_way  = u_hit ? u_hit_way : victim;
        ptr_nxt = (wr_way == vsel_t'(NWAYS - 1)) ? '0 : wr_way + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NSETS; s++) begin
                vld_q[s] <= '0;
                ptr_q[s] <= '0;
            end
        end else if (wr_en) begin
            vld_q[wr_set][wr_way] <= 1'b1;
            ptr_q[wr_set]         <= ptr_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) ent_q[wr_set][wr_way] <= wr_ent;
    end

    // probe side sees the set as it stands after a same-cycle write
    logic fwd;
    assign fwd = wr_en && (wr_set == lk_set);

    always_comb begin
        probe = '0;
        for (int w = 0; w < NWAYS; w++) begin
            logic   v;
            entry_t e;
            v = vld_q[lk_set][w];
            e = ent_q[lk_set][w];
            if (fwd && wr_way == vsel_t'(w)) begin
                v = 1'b1;
                e = wr_ent;
            end
            if (!probe.hit && v && e.tag == lk_tag) begin
                probe.hit    = 1'b1;
                probe.icway  = e.icway;
                probe.taken  = e.taken;
                probe.target = e.target;
            end
        end
    end

endmodule

// File: rtl/wpb_mispredict.sv
module wpb_mispredict (
    input  logic clk,
    input  logic rst,
    input  logic pred_used,
    input  logic resp_valid,
    input  logic resp_hit,
    output logic mispredict
);
    logic pred_q;
    logic misp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pred_q <= 1'b0;
            misp_q <= 1'b0;
        end else begin
            pred_q <= pred_used;
            misp_q <= pred_q && resp_valid && !resp_hit;
        end
    end

    assign mispredict = misp_q;

endmodule

// File: rtl/way_pred_btb.sv
module way_pred_btb
    import wpb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               lk_valid,
    input  logic [ADDR_W-1:0]  lk_addr,
    output logic               lk_hit,
    output logic               lk_is_branch,
    output logic               lk_taken,
    output logic [ADDR_W-1:0]  lk_target,
    output logic               lk_way_valid,
    output logic [WAY_W-1:0]   lk_way,
    output logic [IC_WAYS-1:0] ic_way_en,
    input  logic               up_valid,
    input  logic [ADDR_W-1:0]  up_addr,
    input  logic [WAY_W-1:0]   up_way,
    input  logic               up_is_branch,
    input  logic               up_taken,
    input  logic [ADDR_W-1:0]  up_target,
    input  logic               ic_resp_valid,
    input  logic               ic_resp_hit,
    output logic               way_mispredict
);
    set_t   p_set;
    tag_t   p_tag;
    set_t   u_set;
    probe_t probes [N_GROUPS];

    assign p_set = set_of(lk_addr);
    assign p_tag = tag_of(lk_addr);
    assign u_set = set_of(up_addr);

    generate
        for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
            localparam bit IS_BR = (group_e'(g) == GRP_BRANCH);
            logic   wen;
            entry_t went;
            assign wen          = up_valid && (up_is_branch == IS_BR);
            assign went.tag     = tag_of(up_addr);
            assign went.icway   = up_way;
            assign went.taken   = IS_BR ? up_taken : 1'b0;
            assign went.target  = IS_BR ? up_target : '0;

            wpb_group #(
                .NSETS (SETS),
                .NWAYS (GROUP_WAYS)
            ) u_group (
                .clk    (clk),
                .rst    (rst),
                .lk_set (p_set),
                .lk_tag (p_tag),
                .probe  (probes[g]),
                .wr_en  (wen),
                .wr_set (u_set),
                .wr_ent (went)
            );
        end
    endgenerate

    probe_t br;
    probe_t pl;
    assign br = probes[GRP_BRANCH];
    assign pl = probes[GRP_PLAIN];

    always_comb begin
        lk_hit       = lk_valid && (br.hit || pl.hit);
        lk_is_branch = lk_valid && br.hit;
        lk_taken     = lk_is_branch && br.taken;
        lk_target    = lk_is_branch ? br.target : '0;
        lk_way_valid = lk_hit;
        lk_way       = '0;
        if (lk_is_branch)  lk_way = br.icway;
        else if (lk_hit)   lk_way = pl.icway;
        ic_way_en    = way_enable(lk_way_valid, lk_way);
    end

    wpb_mispredict u_misp (
        .clk        (clk),
        .rst        (rst),
        .pred_used  (lk_valid && lk_way_valid),
        .resp_valid (ic_resp_valid),
        .resp_hit   (ic_resp_hit),
        .mispredict (way_mispredict)
    );

endmodule

// File: rtl/wpb_checker.sv
module wpb_checker
    import wpb_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               lk_valid,
    input logic               lk_hit,
    input logic               lk_is_branch,
    input logic               lk_taken,
    input logic               lk_way_valid,
    input logic [IC_WAYS-1:0] ic_way_en,
    input logic               up_valid,
    input logic               ic_resp_valid,
    input logic               ic_resp_hit,
    input logic               way_mispredict
);
    // R1
    reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !up_valid) |-> !lk_hit);

    // R3
    single_way_chk: assert property (@(posedge clk) disable iff (rst)
        lk_way_valid |-> $onehot(ic_way_en));

    // R3
    all_ways_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_way_valid |-> (ic_way_en == '1));

    // R2
    taken_needs_branch_chk: assert property (@(posedge clk) disable iff (rst)
        lk_taken |-> (lk_is_branch && lk_hit && lk_valid));

    // R4
    pred_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
        lk_way_valid |-> (lk_hit && lk_valid));

    // R10
    misp_cause_chk: assert property (@(posedge clk) disable iff (rst)
        way_mispredict |-> $past(ic_resp_valid && !ic_resp_hit));

endmodule

bind way_pred_btb wpb_checker u_chk (.*);

// File: tb/way_pred_btb_tb.sv
`timescale 1ns/1ps
module way_pred_btb_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        lk_valid;
    logic [31:0] lk_addr;
    logic        lk_hit, lk_is_branch, lk_taken, lk_way_valid;
    logic [31:0] lk_target;
    logic [1:0]  lk_way;
    logic [3:0]  ic_way_en;
    logic        up_valid, up_is_branch, up_taken;
    logic [31:0] up_addr, up_target;
    logic [1:0]  up_way;
    logic        ic_resp_valid, ic_resp_hit;
    logic        way_mispredict;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    way_pred_btb u_dut (.*);

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic train(input logic [31:0] a, input logic [1:0] w, input logic br,
                         input logic tk, input logic [31:0] tgt);
        @(negedge clk);
        up_valid = 1; up_addr = a; up_way = w; up_is_branch = br;
        up_taken = tk; up_target = tgt;
        @(negedge clk);
        up_valid = 0;
    endtask

    task automatic probe(input logic [31:0] a);
        @(negedge clk);
        lk_valid = 1; lk_addr = a;
        #1;
    endtask

    task automatic probe_done();
        lk_valid = 0;
    endtask

    task automatic expect_miss(input string req, input logic [31:0] a);
        probe(a);
        chk(req, "hit", lk_hit, 0);
        chk(req, "way_valid", lk_way_valid, 0);
        chk(req, "way_en", ic_way_en, 4'hF);
        probe_done();
    endtask

    task automatic expect_entry(input string req, input logic [31:0] a, input logic br,
                                input logic tk, input logic [31:0] tgt, input logic [1:0] w);
        probe(a);
        chk(req, "hit", lk_hit, 1);
        chk(req, "is_branch", lk_is_branch, br);
        chk(req, "taken", lk_taken, tk);
        chk(req, "target", lk_target, tgt);
        chk(req, "way_valid", lk_way_valid, 1);
        chk(req, "way", lk_way, w);
        chk(req, "way_en", ic_way_en, 4'b0001 << w);
        probe_done();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
    endtask

    task automatic t_reset();      // R1
        expect_miss("R1", 32'h0000_1014);
        expect_miss("R1", 32'h0000_0000);
    endtask

    task automatic t_branch();     // R2 R3
        train(32'h0000_2040, 2'd2, 1, 1, 32'h0000_0044);
        expect_entry("R2", 32'h0000_2040, 1, 1, 32'h0000_0044, 2'd2);
        expect_entry("R3", 32'h0000_2043, 1, 1, 32'h0000_0044, 2'd2);
    endtask

    task automatic t_plain();      // R4
        train(32'h0000_6088, 2'd1, 0, 1, 32'hDEAD_BEEF);
        expect_entry("R4", 32'h0000_6088, 0, 0, 32'h0, 2'd1);
    endtask

    task automatic t_priority();   // R6
        train(32'h0000_0100, 2'd3, 0, 0, 32'h0);
        train(32'h0000_0100, 2'd1, 1, 1, 32'h0000_8000);
        expect_entry("R6", 32'h0000_0100, 1, 1, 32'h0000_8000, 2'd1);
    endtask

    task automatic t_overwrite();  // R7
        train(32'h0000_2040, 2'd0, 1, 0, 32'h0000_0048);
        expect_entry("R7", 32'h0000_2040, 1, 0, 32'h0000_0048, 2'd0);
        expect_entry("R7", 32'h0000_0100, 1, 1, 32'h0000_8000, 2'd1);
    endtask

    task automatic t_replace();    // R5 R8
        train(32'h0000_4014, 2'd2, 0, 0, 32'h0);
        train(32'h0000_1014, 2'd0, 1, 1, 32'h0000_0A00);
        train(32'h0000_2014, 2'd1, 1, 1, 32'h0000_0B00);
        train(32'h0000_3014, 2'd3, 1, 0, 32'h0000_0C00);
        expect_miss("R8", 32'h0000_1014);
        expect_entry("R8", 32'h0000_2014, 1, 1, 32'h0000_0B00, 2'd1);
        expect_entry("R8", 32'h0000_3014, 1, 0, 32'h0000_0C00, 2'd3);
        expect_entry("R5", 32'h0000_4014, 0, 0, 32'h0, 2'd2);
    endtask

    task automatic t_forward();    // R9
        @(negedge clk);
        up_valid = 1; up_addr = 32'h0000_5080; up_way = 2'd3; up_is_branch = 1;
        up_taken = 1; up_target = 32'h0000_1234;
        lk_valid = 1; lk_addr = 32'h0000_5080;
        #1;
        chk("R9", "hit", lk_hit, 1);
        chk("R9", "way", lk_way, 3);
        chk("R9", "target", lk_target, 32'h0000_1234);
        chk("R9", "way_en", ic_way_en, 4'b1000);
        @(negedge clk);
        up_valid = 0; lk_valid = 0;
        expect_entry("R9", 32'h0000_5080, 1, 1, 32'h0000_1234, 2'd3);
    endtask

    task automatic misp_case(input logic [31:0] a, input logic cache_hit, input logic exp_pulse);
        @(negedge clk);
        lk_valid = 1; lk_addr = a;
        @(negedge clk);
        lk_valid = 0; ic_resp_valid = 1; ic_resp_hit = cache_hit;
        #1;
        chk("R10", "mispredict early", way_mispredict, 0);
        @(negedge clk);
        ic_resp_valid = 0; ic_resp_hit = 0;
        #1;
        chk("R10", "mispredict pulse", way_mispredict, exp_pulse);
        @(negedge clk);
        #1;
        chk("R10", "mispredict end", way_mispredict, 0);
    endtask

    task automatic t_mispredict(); // R10
        misp_case(32'h0000_2040, 0, 1);
        misp_case(32'h0000_2040, 1, 0);
        misp_case(32'h0000_7FFC, 0, 0);
    endtask

    task automatic t_reset_clears(); // R1
        do_reset();
        expect_miss("R1", 32'h0000_2040);
        expect_miss("R1", 32'h0000_6088);
    endtask

    initial begin
        rst = 1; lk_valid = 0; lk_addr = 0;
        up_valid = 0; up_addr = 0; up_way = 0; up_is_branch = 0; up_taken = 0; up_target = 0;
        ic_resp_valid = 0; ic_resp_hit = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_branch();
        t_plain();
        t_priority();
        t_overwrite();
        t_replace();
        t_forward();
        t_mispredict();
        t_reset_clears();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule